// File: doc/BRIEF.md
# Serial-Loaded Memory Bank Mapper

This block sits on the write side of an 8-bit CPU bus. It turns a stream of single-bit stores into four five-bit configuration registers that steer program-ROM and character-memory banking. The CPU places one data bit per store anywhere in the upper half of its address space (address bit 15 high). A store with data bit 7 set aborts the sequence in progress. The fifth accepted bit commits the assembled value. The address of that fifth store, and only that one, picks the destination register.

From the registers the block derives the upper program-ROM address bits for the $8000 half and the $C000 half of the program window, the character bank numbers for the two 4 KB character halves, a program-RAM enable and a raw two-bit layout field. The layout field is left for a neighbouring block to decode. After power-on reset the block is in a known state: the upper program half holds the last bank and program RAM is enabled. Boot code can therefore rely on its reset vector without priming the mapper first.

Top module: `serial_bank_mapper`

## Requirements
- R1: Each accepted data store (data bit 7 clear) shifts in data bit 0, least-significant bit first. The fifth accepted data store commits the five collected bits to a register on the clock edge that samples it, and clears the collection so the next sequence starts empty.
- R2: The destination is chosen by address bits 14:13 of the committing store only: 00 control, 01 character bank A, 10 character bank B, 11 program bank. The addresses of the first four stores have no effect.
- R3: An accepted store with data bit 7 set empties the collection and the bit count and is not counted as a bit. It sets control bits 3:2 to 11 and leaves control bits 4 and 1:0 unchanged.
- R4: A store on the clock edge directly after an edge that saw `cpu_wr` high is ignored entirely, whatever its data.
- R5: Cycles with `cpu_wr` low, or stores with address bit 15 low, change no output and no collection state.
- R6: After `rst_n` is released: control = 01100, both character registers = 0, program register = 0, so `prg_hi_bank` is the last bank and `prg_ram_en` is 1.
- R7: Program mode (control bits 3:2) 00 or 01: `prg_lo_bank` = program bank with bit 0 cleared, `prg_hi_bank` = the same with bit 0 set.
- R8: Program mode 10: `prg_lo_bank` = 0, `prg_hi_bank` = program bank.
- R9: Program mode 11: `prg_lo_bank` = program bank, `prg_hi_bank` = all ones (last bank).
- R10: `prg_ram_en` is the inverse of program register bit 4. The program bank is program register bits PRG_BANK_W-1:0.
- R11: Control bit 4 = 0: the character outputs are bank A with bit 0 cleared and set. Control bit 4 = 1: `chr_lo_bank` = bank A and `chr_hi_bank` = bank B. `layout_sel` always shows control bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cpu_wr | input | 1 | Store strobe, high for one cycle per store |
| cpu_addr_top | input | 3 | CPU address bits 15:13 |
| cpu_wdata_lsb | input | 1 | CPU data bit 0 |
| cpu_wdata_msb | input | 1 | CPU data bit 7 |
| prg_lo_bank | output | PRG_BANK_W | Program bank for $8000-$BFFF |
| prg_hi_bank | output | PRG_BANK_W | Program bank for $C000-$FFFF |
| prg_ram_en | output | 1 | Program RAM enable |
| chr_lo_bank | output | 5 | Character bank for the lower 4 KB |
| chr_hi_bank | output | 5 | Character bank for the upper 4 KB |
| layout_sel | output | 2 | Raw layout field for a neighbouring decoder |

## Verification
Commit and store suppression can meet on one edge. So can commit and the bit-7 abort. The bench places a fifth store straight after the fourth so that it is discarded, and places an abort store in the fifth slot so that it replaces the commit. It then completes the sequence and compares every output with a bench model that applies the acceptance rule first. A back-to-back pair of a data store followed by an abort store is also driven. In that case the abort must be lost, and the next five bits must land in the register chosen by the fifth address.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    localparam int SHIFT_LEN = 5;
    localparam int CNT_W     = $clog2(SHIFT_LEN + 1);

    typedef enum logic [1:0] {
        SEL_CTRL = 2'b00,
        SEL_CHRA = 2'b01,
        SEL_CHRB = 2'b10,
        SEL_PRG  = 2'b11
    } reg_sel_e;

    typedef enum logic [1:0] {
        PM_SPAN_A    = 2'b00,
        PM_SPAN_B    = 2'b01,
        PM_FIX_FIRST = 2'b10,
        PM_FIX_LAST  = 2'b11
    } prg_mode_e;

    typedef struct packed {
        logic [SHIFT_LEN-1:0] shift;
        logic [CNT_W-1:0]     cnt;
        logic                 prev_wr;
    } loader_t;

    typedef struct packed {
        logic [SHIFT_LEN-1:0] ctrl;
        logic [SHIFT_LEN-1:0] chra;
        logic [SHIFT_LEN-1:0] chrb;
        logic [SHIFT_LEN-1:0] prg;
    } regs_t;

    localparam logic [SHIFT_LEN-1:0] CTRL_POWER_ON = 5'b01100;
    localparam logic [SHIFT_LEN-1:0] CTRL_MODE_SET = 5'b01100;

endpackage

// File: rtl/serial_loader.sv
module serial_loader
    import mapper_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [2:0]           addr_top,
    input  logic                 bit_lsb,
    input  logic                 bit_msb,
    output logic                 commit,
    output reg_sel_e             commit_sel,
    output logic [SHIFT_LEN-1:0] commit_val,
    output logic                 abort
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SHIFT_LEN - 1);

    loader_t st_d, st_q;
    logic    accept;

    always_comb begin
        st_d         = st_q;
        st_d.prev_wr = wr;
        commit       = 1'b0;
        abort        = 1'b0;
        accept       = wr && addr_top[2] && !st_q.prev_wr;
        commit_sel   = reg_sel_e'(addr_top[1:0]);
        commit_val   = {bit_lsb, st_q.shift[SHIFT_LEN-1:1]};
        if (accept) begin
            if (bit_msb) begin
                abort      = 1'b1;
                st_d.shift = '0;
                st_d.cnt   = '0;
            end else if (st_q.cnt == LAST_IDX) begin
                commit     = 1'b1;
                st_d.shift = '0;
                st_d.cnt   = '0;
            end else begin
                st_d.shift = {bit_lsb, st_q.shift[SHIFT_LEN-1:1]};
                st_d.cnt   = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bank_regs.sv
module bank_regs
    import mapper_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit,
    input  reg_sel_e             commit_sel,
    input  logic [SHIFT_LEN-1:0] commit_val,
    input  logic                 abort,
    output regs_t                regs
);

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (abort) begin
            regs_d.ctrl = regs_q.ctrl | CTRL_MODE_SET;
        end else if (commit) begin
            unique case (commit_sel)
                SEL_CTRL: regs_d.ctrl = commit_val;
                SEL_CHRA: regs_d.chra = commit_val;
                SEL_CHRB: regs_d.chrb = commit_val;
                SEL_PRG:  regs_d.prg  = commit_val;
                default:  regs_d      = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.ctrl <= CTRL_POWER_ON;
            regs_q.chra <= '0;
            regs_q.chrb <= '0;
            regs_q.prg  <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs = regs_q;

endmodule

// File: rtl/prg_map.sv
module prg_map
    import mapper_pkg::*;
#(
    parameter int PRG_BANK_W = 4
) (
    input  logic [1:0]            mode,
    input  logic [PRG_BANK_W-1:0] bank,
    output logic [PRG_BANK_W-1:0] lo_bank,
    output logic [PRG_BANK_W-1:0] hi_bank
);

    localparam logic [PRG_BANK_W-1:0] LAST_BANK = '1;

    logic [PRG_BANK_W-1:0] even_bank;
    logic [PRG_BANK_W-1:0] odd_bank;

    generate
        if (PRG_BANK_W == 1) begin : g_one_bit
            assign even_bank = 1'b0;
            assign odd_bank  = 1'b1;
        end else begin : g_wide
            assign even_bank = {bank[PRG_BANK_W-1:1], 1'b0};
            assign odd_bank  = {bank[PRG_BANK_W-1:1], 1'b1};
        end
    endgenerate

    always_comb begin
        unique case (prg_mode_e'(mode))
            PM_SPAN_A, PM_SPAN_B: begin
                lo_bank = even_bank;
                hi_bank = odd_bank;
            end
            PM_FIX_FIRST: begin
                lo_bank = '0;
                hi_bank = bank;
            end
            PM_FIX_LAST: begin
                lo_bank = bank;
                hi_bank = LAST_BANK;
            end
            default: begin
                lo_bank = bank;
                hi_bank = LAST_BANK;
            end
        endcase
    end

endmodule

// File: rtl/chr_map.sv
module chr_map
    import mapper_pkg::*;
(
    input  logic                 split,
    input  logic [SHIFT_LEN-1:0] bank_a,
    input  logic [SHIFT_LEN-1:0] bank_b,
    output logic [SHIFT_LEN-1:0] lo_bank,
    output logic [SHIFT_LEN-1:0] hi_bank
);

    always_comb begin
        if (split) begin
            lo_bank = bank_a;
            hi_bank = bank_b;
        end else begin
            lo_bank = {bank_a[SHIFT_LEN-1:1], 1'b0};
            hi_bank = {bank_a[SHIFT_LEN-1:1], 1'b1};
        end
    end

endmodule

// File: rtl/serial_bank_mapper.sv
module serial_bank_mapper
    import mapper_pkg::*;
#(
    parameter int PRG_BANK_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_wr,
    input  logic [2:0]            cpu_addr_top,
    input  logic                  cpu_wdata_lsb,
    input  logic                  cpu_wdata_msb,
    output logic [PRG_BANK_W-1:0] prg_lo_bank,
    output logic [PRG_BANK_W-1:0] prg_hi_bank,
    output logic                  prg_ram_en,
    output logic [SHIFT_LEN-1:0]  chr_lo_bank,
    output logic [SHIFT_LEN-1:0]  chr_hi_bank,
    output logic [1:0]            layout_sel
);

    localparam int RAM_OFF_BIT = SHIFT_LEN - 1;

    logic                 commit;
    reg_sel_e             commit_sel;
    logic [SHIFT_LEN-1:0] commit_val;
    logic                 abort;
    regs_t                regs;

    serial_loader u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (cpu_wr),
        .addr_top   (cpu_addr_top),
        .bit_lsb    (cpu_wdata_lsb),
        .bit_msb    (cpu_wdata_msb),
        .commit     (commit),
        .commit_sel (commit_sel),
        .commit_val (commit_val),
        .abort      (abort)
    );

    bank_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .commit_sel (commit_sel),
        .commit_val (commit_val),
        .abort      (abort),
        .regs       (regs)
    );

    prg_map #(.PRG_BANK_W(PRG_BANK_W)) u_prg (
        .mode    (regs.ctrl[3:2]),
        .bank    (regs.prg[PRG_BANK_W-1:0]),
        .lo_bank (prg_lo_bank),
        .hi_bank (prg_hi_bank)
    );

    chr_map u_chr (
        .split   (regs.ctrl[4]),
        .bank_a  (regs.chra),
        .bank_b  (regs.chrb),
        .lo_bank (chr_lo_bank),
        .hi_bank (chr_hi_bank)
    );

    assign prg_ram_en = ~regs.prg[RAM_OFF_BIT];
    assign layout_sel = regs.ctrl[1:0];

endmodule

// File: rtl/serial_bank_mapper_chk.sv
module serial_bank_mapper_chk #(
    parameter int PRG_BANK_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cpu_wr,
    input logic [2:0]            cpu_addr_top,
    input logic                  cpu_wdata_msb,
    input logic [PRG_BANK_W-1:0] prg_lo_bank,
    input logic [PRG_BANK_W-1:0] prg_hi_bank,
    input logic                  prg_ram_en,
    input logic [4:0]            chr_lo_bank,
    input logic [4:0]            chr_hi_bank,
    input logic [1:0]            layout_sel,
    input logic [4:0]            ctrl_q
);

    localparam logic [PRG_BANK_W-1:0] ONE_BANK = PRG_BANK_W'(1);

    logic prev_wr_q;
    logic [PRG_BANK_W*2+14-1:0] outs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_wr_q <= 1'b0;
        else        prev_wr_q <= cpu_wr;
    end

    assign outs = {prg_lo_bank, prg_hi_bank, prg_ram_en, chr_lo_bank, chr_hi_bank, layout_sel, 1'b0};

    a_r4_back_to_back_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && prev_wr_q) |=> $stable(outs));

    a_r5_no_store_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_wr || !cpu_addr_top[2]) |=> $stable(outs));

    a_r3_abort_fixes_last: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr_top[2] && cpu_wdata_msb && !prev_wr_q)
        |=> (prg_hi_bank == '1) && $stable(layout_sel));

    a_r7_span_pair: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[3] |-> (!prg_lo_bank[0] && prg_hi_bank == (prg_lo_bank | ONE_BANK)));

    a_r8_fix_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[3:2] == 2'b10) |-> (prg_lo_bank == '0));

    a_r9_fix_last: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[3:2] == 2'b11) |-> (prg_hi_bank == '1));

    a_r11_chr_pair: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[4] |-> (!chr_lo_bank[0] && chr_hi_bank == (chr_lo_bank | 5'd1)));

endmodule

bind serial_bank_mapper serial_bank_mapper_chk #(.PRG_BANK_W(PRG_BANK_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_wr        (cpu_wr),
    .cpu_addr_top  (cpu_addr_top),
    .cpu_wdata_msb (cpu_wdata_msb),
    .prg_lo_bank   (prg_lo_bank),
    .prg_hi_bank   (prg_hi_bank),
    .prg_ram_en    (prg_ram_en),
    .chr_lo_bank   (chr_lo_bank),
    .chr_hi_bank   (chr_hi_bank),
    .layout_sel    (layout_sel),
    .ctrl_q        (regs.ctrl)
);

// File: tb/tb_serial_bank_mapper.sv
`timescale 1ns/1ps
module tb_serial_bank_mapper;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr = 1'b0;
    logic [2:0] at = 3'b000;
    logic       d0 = 1'b0;
    logic       d7 = 1'b0;
    logic [3:0] prg_lo, prg_hi;
    logic       ram_en;
    logic [4:0] chr_lo, chr_hi;
    logic [1:0] layout;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bit [4:0] m_ctrl, m_chra, m_chrb, m_prg, m_shift;
    int       m_cnt;
    bit       m_prev;

    always #4 clk = ~clk;

    serial_bank_mapper #(.PRG_BANK_W(4)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_wr        (wr),
        .cpu_addr_top  (at),
        .cpu_wdata_lsb (d0),
        .cpu_wdata_msb (d7),
        .prg_lo_bank   (prg_lo),
        .prg_hi_bank   (prg_hi),
        .prg_ram_en    (ram_en),
        .chr_lo_bank   (chr_lo),
        .chr_hi_bank   (chr_hi),
        .layout_sel    (layout)
    );

    task automatic model_reset();
        m_ctrl = 5'b01100; m_chra = 0; m_chrb = 0; m_prg = 0;
        m_shift = 0; m_cnt = 0; m_prev = 0;
    endtask

    task automatic cyc(input bit w, input bit [2:0] a, input bit b0, input bit b7);
        bit acc;
        bit [4:0] val;
        @(negedge clk);
        wr = w; at = a; d0 = b0; d7 = b7;
        acc = w && a[2] && !m_prev;
        m_prev = w;
        if (acc) begin
            if (b7) begin
                m_shift = 0; m_cnt = 0; m_ctrl = m_ctrl | 5'b01100;
            end else if (m_cnt == 4) begin
                val = {b0, m_shift[4:1]};
                case (a[1:0])
                    2'b00: m_ctrl = val;
                    2'b01: m_chra = val;
                    2'b10: m_chrb = val;
                    default: m_prg = val;
                endcase
                m_shift = 0; m_cnt = 0;
            end else begin
                m_shift = {b0, m_shift[4:1]};
                m_cnt++;
            end
        end
    endtask

    task automatic write5(input int sel, input bit [4:0] v);
        for (int i = 0; i < 5; i++) begin
            bit [1:0] s;
            s = (i < 4) ? 2'((sel + i + 1) % 4) : 2'(sel);
            cyc(1'b1, {1'b1, s}, v[i], 1'b0);
            cyc(1'b0, 3'b000, 1'b0, 1'b0);
        end
    endtask

    task automatic cmp(input string tag, input string nm, input int act, input int exp, inout bit bad);
        if (act != exp) begin
            $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
            bad = 1;
        end
    endtask

    task automatic chk(input string tag);
        bit [3:0] bank, elo, ehi;
        bit [4:0] clo, chi;
        bit bad;
        cyc(1'b0, 3'b000, 1'b0, 1'b0);
        bank = m_prg[3:0];
        case (m_ctrl[3:2])
            2'b00, 2'b01: begin elo = bank & 4'hE; ehi = bank | 4'h1; end
            2'b10:        begin elo = 4'h0; ehi = bank; end
            default:      begin elo = bank; ehi = 4'hF; end
        endcase
        if (m_ctrl[4]) begin clo = m_chra; chi = m_chrb; end
        else begin clo = m_chra & 5'h1E; chi = m_chra | 5'h01; end
        bad = 0;
        checks++;
        cmp(tag, "prg_lo_bank", prg_lo, elo, bad);
        cmp(tag, "prg_hi_bank", prg_hi, ehi, bad);
        cmp(tag, "prg_ram_en", ram_en, !m_prg[4], bad);
        cmp(tag, "chr_lo_bank", chr_lo, clo, bad);
        cmp(tag, "chr_hi_bank", chr_hi, chi, bad);
        cmp(tag, "layout_sel", layout, m_ctrl[1:0], bad);
        if (bad) failures++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; wr = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R6 power-on");

        // R7 R8 R9 R10 R2 R1: every control value against every program value
        for (int c = 0; c < 32; c++) begin
            write5(0, 5'(c));
            chk("R2 R1 control commit");
            for (int p = 0; p < 32; p++) begin
                write5(3, 5'(p));
                if (c[3] == 0)      chk("R7 R10 span mode");
                else if (c[2] == 0) chk("R8 R10 fix-first mode");
                else                chk("R9 R10 fix-last mode");
            end
        end

        // R11: character modes, both banks
        for (int c = 0; c < 2; c++) begin
            write5(0, c ? 5'b10001 : 5'b00010);
            for (int v = 0; v < 32; v++) begin
                write5(1, 5'(v));
                chk("R11 bank A");
                write5(2, 5'(31 - v));
                chk("R11 R2 bank B");
            end
        end

        // R3: abort mid-sequence, then clean sequence
        write5(0, 5'b00000);
        cyc(1, 3'b111, 1, 0); cyc(0, 0, 0, 0);
        cyc(1, 3'b111, 1, 0); cyc(0, 0, 0, 0);
        cyc(1, 3'b100, 1, 1);
        chk("R3 abort sets fix-last mode");
        write5(3, 5'd5);
        chk("R3 R1 abort emptied collection");
        // R3: abort in the fifth slot replaces commit
        for (int i = 0; i < 4; i++) begin cyc(1, 3'b101, 1, 0); cyc(0, 0, 0, 0); end
        cyc(1, 3'b101, 1, 1);
        chk("R3 abort on fifth slot");
        write5(1, 5'd9);
        chk("R3 bank A after abort");
        // R3: other control bits preserved
        write5(0, 5'b10010);
        cyc(1, 3'b110, 0, 1);
        chk("R3 control bits 4 and 1:0 kept");

        // R4: fifth store back to back with fourth is dropped
        write5(0, 5'b01100);
        for (int i = 0; i < 3; i++) begin cyc(1, 3'b111, 1, 0); cyc(0, 0, 0, 0); end
        cyc(1, 3'b111, 0, 0);
        cyc(1, 3'b111, 1, 0);
        chk("R4 second of pair ignored");
        cyc(1, 3'b111, 0, 0);
        chk("R4 commit after pair");
        // R4: abort right behind a data store is lost
        cyc(1, 3'b100, 1, 0);
        cyc(1, 3'b100, 0, 1);
        cyc(0, 0, 0, 0);
        for (int i = 0; i < 4; i++) begin cyc(1, 3'b110, 0, 0); cyc(0, 0, 0, 0); end
        chk("R4 lost abort");
        write5(2, 5'd21);
        chk("R4 R2 realigned sequence");

        // R5: stores below the window and idle cycles
        for (int i = 0; i < 5; i++) begin cyc(1, 3'b011, 1, 0); cyc(0, 0, 0, 0); end
        chk("R5 low-half stores ignored");
        cyc(1, 3'b111, 1, 0); cyc(0, 0, 0, 0);
        cyc(1, 3'b001, 0, 1); cyc(0, 0, 0, 0);
        cyc(0, 3'b111, 0, 1); cyc(0, 0, 0, 0);
        for (int i = 0; i < 4; i++) begin cyc(1, 3'b111, 1, 0); cyc(0, 0, 0, 0); end
        chk("R5 interleaved ignored stores");

        do_reset();
        chk("R6 second reset");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule